// File: doc/BRIEF.md
# Serial converter port with edge-counted framing

This block is the serial interface of a data converter, acting as the target on an SPI link. A host shifts a command word in on SDI while the block shifts a conversion word out on SDO. The block does not depend on chip select to find word boundaries. While chip select stays low, it counts SCLK rising edges and closes each frame on the last bit. The first time chip select is seen high after reset, the port switches to chip-select framing. It stays in that mode until the next reset. From then on, every rising edge of chip select closes a frame.

A separate divider raises a one-cycle data-ready pulse at a fixed rate while the start input is high. Each pulse stands for a finished conversion. The value of that conversion is either an internal count of finished conversions or a word taken from a test input. The output register picks up a new result only at a frame boundary, so a word never changes partway through a frame.

Each frame also carries a command. A well-formed write command stores one byte into a small register file. One bit of that register file turns on a status byte, which makes every frame 32 bits instead of 24. The status byte is an XOR signature of all configuration registers, with two mode flags folded into its top bits.

Top module: `spi_frame_target`

## Requirements
- R1: After reset the port uses edge-counted framing and 24-bit frames. All configuration registers are zero, SDO is 0, data-ready is low, and the first frame shifts out an all-zero word.
- R2: While chip select is low and edge-counted framing is active, the frame ends on the rising SCLK edge that completes the frame length. The next rising edges start the next frame with no other signal needed, so 24-bit frames run back to back.
- R3: SDI is sampled on rising SCLK edges. SDO changes only on falling SCLK edges or at a frame boundary. Each frame's first bit, which is its MSB, is on SDO before that frame's first rising edge.
- R4: A frame is a write when all three of these hold:
  - all bits above the low 16 are zero;
  - bits [15:12] of the low 16 equal 4'h8;
  - exactly one frame length of bits was received.
  When it is a write, bits [7:0] are stored into the register whose address is bits [11:8].
- R5: A command whose bits [15:12] are anything other than 4'h8 changes no register. A command with a nonzero bit above bit 15 also changes no register.
- R6: Bit 0 of register 1 is the status enable. When a write sets it, the very next frame is 32 bits long. In a 32-bit frame, SDI carries 16 zero bits and then the command. SDO carries the status byte and then the 24-bit result. The status byte is the XOR of all 16 registers, with bit 7 inverted when chip-select framing is active and bit 6 inverted when the test input is selected.
- R7: When chip select is high in any cycle after reset, chip-select framing becomes active and stays active until reset. In that mode a rising edge of chip select ends the frame. SCLK edges that arrive while chip select is high are ignored.
- R8: While start is high, data-ready pulses high for exactly one clock every RATE_DIV clocks. The first pulse comes RATE_DIV clocks after start rises. While start is low, no pulse occurs and the divider restarts.
- R9: A conversion result is loaded at the first frame boundary after a data-ready pulse. If no pulse occurs between two boundaries, the next frame repeats the previous word.
- R10: When the test select is high, the result is the test input word. When it is low, the result is a count of data-ready pulses since reset.
- R11: In chip-select framing, a frame whose number of received bits differs from the current frame length writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial inputs are sampled with it |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock from the host, already synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial command data from the host |
| start | input | 1 | Runs conversions while high |
| test_en | input | 1 | Selects the test word as the conversion result |
| test_word | input | DATA_W | Result used when test_en is high |
| sdo | output | 1 | Serial result data, MSB first |
| drdy | output | 1 | One-clock pulse per finished conversion |

## Verification
All serial inputs go through one register before their edges are detected.
- A falling SCLK edge moves SDO on the next clk edge.
- A rising edge of chip select, or the final rising SCLK edge of an edge-counted frame, loads the next word within that same clk cycle.

The bench drives inputs on falling clk edges and holds each SCLK level for four clk cycles. It reads SDO just before it raises SCLK, so every bit it reads has settled at least three cycles earlier. Data-ready is due RATE_DIV clocks after start rises and then every RATE_DIV clocks; the bench counts falling clk edges between pulses and compares that count with RATE_DIV exactly. A new result can only show up one frame after the boundary that captured it, so every vector waits longer than one data-ready period before its frame and compares the frame that follows.

// File: rtl/spi_tgt_pkg.sv
// Package: shared constants for the serial converter port.
// Assumes a command layout of opcode nibble, address nibble, data byte.
package spi_tgt_pkg;
    localparam logic [3:0] OP_WRITE   = 4'h8;
    localparam int         OP_W       = 4;
    localparam int         ADDR_NIB_W = 4;
endpackage

// File: rtl/spi_tgt_edge.sv
// Edge detector for a group of inputs that are already synchronous to clk.
// A rise or fall is reported in the cycle the new level is first seen.
module spi_tgt_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    // Keep the previous level of every input; all inputs rest low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // One detector for each input bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_det
        assign rise[g] =  din[g] & ~prev_q[g];
        assign fall[g] = ~din[g] &  prev_q[g];
    end
endmodule

// File: rtl/spi_tgt_rate.sv
// Conversion timer and result source. While start is high it pulses drdy
// once every RATE_DIV clocks and counts the pulses. The result word is
// either that count or the test input. Assumes RATE_DIV >= 2.
module spi_tgt_rate #(
    parameter int DATA_W   = 24,
    parameter int RATE_DIV = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              test_en,
    input  logic [DATA_W-1:0] test_word,
    output logic              drdy,
    output logic [DATA_W-1:0] result
);
    localparam int DIV_W = $clog2(RATE_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RATE_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] conv_q;

    // Divider, pulse and conversion count; the divider restarts while start is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            drdy   <= 1'b0;
            conv_q <= '0;
        end else if (!start) begin
            div_q  <= '0;
            drdy   <= 1'b0;
        end else if (div_q == DIV_LAST) begin
            div_q  <= '0;
            drdy   <= 1'b1;
            conv_q <= conv_q + 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            drdy   <= 1'b0;
        end
    end

    // Pick the result source.
    assign result = test_en ? test_word : conv_q;
endmodule

// File: rtl/spi_tgt_regs.sv
// Command decoder and configuration registers. When a frame closes, the
// received bits are checked: the padding must be zero, the opcode must be
// a write, and the bit count must equal the frame length. A valid write
// stores one register. The outputs are the next-cycle register values, so
// the frame right after a write already uses them.
module spi_tgt_regs
    import spi_tgt_pkg::*;
#(
    parameter int FRAME_MAX = 32,
    parameter int CMD_W     = 16,
    parameter int REG_W     = 8,
    parameter int NUM_REGS  = 16,
    parameter int STAT_ADDR = 1,
    parameter int STAT_BIT  = 0,
    parameter int CNT_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic [FRAME_MAX-1:0] cmd_bits,
    input  logic [CNT_W-1:0]     bits_seen,
    input  logic [CNT_W-1:0]     frame_len,
    output logic                 stat_en_next,
    output logic [REG_W-1:0]     cfg_sig
);
    logic [REG_W-1:0] regs_q [NUM_REGS];
    logic [REG_W-1:0] regs_d [NUM_REGS];
    logic [OP_W-1:0]       opcode;
    logic [ADDR_NIB_W-1:0] addr;
    logic [REG_W-1:0]      wdata;
    logic                  pad_zero;
    logic                  wr_ok;

    assign opcode   = cmd_bits[CMD_W-1 -: OP_W];
    assign addr     = cmd_bits[CMD_W-OP_W-1 -: ADDR_NIB_W];
    assign wdata    = cmd_bits[REG_W-1:0];
    assign pad_zero = (cmd_bits[FRAME_MAX-1:CMD_W] == '0);

    // A write is accepted only for a full-length, zero-padded frame with the write opcode.
    assign wr_ok = frame_end && (bits_seen == frame_len) && pad_zero && (opcode == OP_WRITE);

    // One storage slot per register address.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign regs_d[g] = (wr_ok && addr == ADDR_NIB_W'(g)) ? wdata : regs_q[g];

        // Hold or update this register.
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    // Fold every register into the signature sent in the status byte.
    always_comb begin
        cfg_sig = '0;
        for (int i = 0; i < NUM_REGS; i++) cfg_sig = cfg_sig ^ regs_d[i];
    end

    assign stat_en_next = regs_d[STAT_ADDR][STAT_BIT];
endmodule

// File: rtl/spi_frame_target.sv
// Top of the serial converter port. Its clock oversamples SCLK, chip select
// and SDI, which the host keeps synchronous to clk. With chip select held low,
// frames are found by counting rising SCLK edges. Once chip select is seen
// high, chip-select framing stays active until reset. SDO moves on falling
// SCLK edges, and each new frame is loaded at the frame boundary.
module spi_frame_target #(
    parameter int DATA_W   = 24,
    parameter int STAT_W   = 8,
    parameter int CMD_W    = 16,
    parameter int NUM_REGS = 16,
    parameter int RATE_DIV = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              start,
    input  logic              test_en,
    input  logic [DATA_W-1:0] test_word,
    output logic              sdo,
    output logic              drdy
);
    localparam int FRAME_MAX = DATA_W + STAT_W;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_MAX);
    localparam logic [CNT_W-1:0] CNT_SAT   = '1;

    logic [1:0]           rise_v, fall_v;
    logic                 sclk_rise, sclk_fall, cs_rise;
    logic                 rise_ok, count_end, frame_end;
    logic                 mode4_q, seen_q, len32_q, pend_q, mode_next;
    logic [CNT_W-1:0]     bit_cnt_q, bits_done, frame_len;
    logic [FRAME_MAX-1:0] in_sr_q, in_next, out_sr_q, load_word;
    logic [DATA_W-1:0]    held_q, next_word, result;
    logic                 stat_en_next;
    logic [STAT_W-1:0]    cfg_sig, status;

    spi_tgt_edge #(.WIDTH(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sclk}), .rise(rise_v), .fall(fall_v)
    );
    assign sclk_rise = rise_v[0];
    assign sclk_fall = fall_v[0];
    assign cs_rise   = rise_v[1];

    spi_tgt_rate #(.DATA_W(DATA_W), .RATE_DIV(RATE_DIV)) u_rate (
        .clk(clk), .rst_n(rst_n), .start(start), .test_en(test_en),
        .test_word(test_word), .drdy(drdy), .result(result)
    );

    // Frame length, edge qualification and boundary detection.
    assign frame_len = len32_q ? LEN_LONG : LEN_SHORT;
    assign rise_ok   = sclk_rise & ~cs_n;
    assign count_end = ~mode4_q & rise_ok & (bit_cnt_q == frame_len - 1'b1);
    assign frame_end = cs_rise | count_end;
    assign in_next   = rise_ok ? {in_sr_q[FRAME_MAX-2:0], sdi} : in_sr_q;
    assign bits_done = (rise_ok && bit_cnt_q != CNT_SAT) ? bit_cnt_q + 1'b1 : bit_cnt_q;

    spi_tgt_regs #(
        .FRAME_MAX(FRAME_MAX), .CMD_W(CMD_W), .REG_W(STAT_W), .NUM_REGS(NUM_REGS),
        .STAT_ADDR(1), .STAT_BIT(0), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cmd_bits(in_next),
        .bits_seen(bits_done), .frame_len(frame_len),
        .stat_en_next(stat_en_next), .cfg_sig(cfg_sig)
    );

    // Word for the next frame: a fresh result only if a conversion finished since the last boundary.
    assign mode_next = mode4_q | cs_n;
    assign next_word = pend_q ? result : held_q;
    assign status    = cfg_sig ^ {mode_next, test_en, {(STAT_W-2){1'b0}}};
    assign load_word = stat_en_next ? {status, next_word} : {next_word, {STAT_W{1'b0}}};

    // Framing state, the sticky mode latch, and the input and output shifters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode4_q   <= 1'b0;
            bit_cnt_q <= '0;
            seen_q    <= 1'b0;
            len32_q   <= 1'b0;
            pend_q    <= 1'b0;
            held_q    <= '0;
            in_sr_q   <= '0;
            out_sr_q  <= '0;
        end else begin
            mode4_q <= mode_next;
            if (drdy) pend_q <= 1'b1;
            if (frame_end) begin
                bit_cnt_q <= '0;
                seen_q    <= 1'b0;
                in_sr_q   <= '0;
                len32_q   <= stat_en_next;
                held_q    <= next_word;
                pend_q    <= drdy;
                out_sr_q  <= load_word;
            end else begin
                if (rise_ok) begin
                    in_sr_q   <= in_next;
                    bit_cnt_q <= bits_done;
                    seen_q    <= 1'b1;
                end
                if (sclk_fall && seen_q && !cs_n)
                    out_sr_q <= {out_sr_q[FRAME_MAX-2:0], 1'b0};
            end
        end
    end

    assign sdo = out_sr_q[FRAME_MAX-1];
endmodule

// File: rtl/spi_frame_target_chk.sv
// Property checker for the serial converter port, bound to the top module.
module spi_frame_target_chk #(
    parameter int FRAME_MAX = 32,
    parameter int CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             start,
    input logic             sdo,
    input logic             drdy,
    input logic             mode4,
    input logic             sclk_fall,
    input logic             frame_end,
    input logic [CNT_W-1:0] bit_cnt
);
    // R7: chip-select framing never falls back before reset.
    a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n) mode4 |=> mode4);
    // R7: chip select seen high enables chip-select framing.
    a_r7_cs_sets_mode: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> mode4);
    // R8: a data-ready pulse lasts one clock.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) drdy |=> !drdy);
    // R8: no pulse while start is low.
    a_r8_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !drdy);
    // R3: SDO moves only on a falling SCLK edge or a frame boundary.
    a_r3_sdo_timing: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall || frame_end) |=> $stable(sdo));
    // R2: with edge-counted framing the bit count stays inside one frame.
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !mode4 |-> (bit_cnt < CNT_W'(FRAME_MAX)));
endmodule

bind spi_frame_target spi_frame_target_chk #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .sdo(sdo), .drdy(drdy),
    .mode4(mode4_q), .sclk_fall(sclk_fall), .frame_end(frame_end), .bit_cnt(bit_cnt_q)
);

// File: tb/sim_spi_frame_target.sv
module sim_spi_frame_target;
    localparam int DATA_W = 24;
    localparam int DIV    = 625;
    localparam int NVEC   = 6;
    // Each entry: {command sent on SDI (24 bits), test word offered (24 bits)}.
    localparam logic [47:0] VEC [NVEC] = '{
        {24'h008355, 24'h12A5C3},
        {24'h009101, 24'h7F0081},   // bad opcode to status register: R5
        {24'h018101, 24'hC35A96},   // nonzero padding: R5
        {24'h008A0F, 24'h000001},
        {24'h008300, 24'hFFFFFE},
        {24'h0082C3, 24'h5A5A5A}
    };

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b0, sdi = 1'b0;
    logic start = 1'b0, test_en = 1'b1;
    logic [DATA_W-1:0] test_word = '0;
    logic sdo, drdy;
    int checks = 0, fails = 0;
    logic [7:0] mreg [16];

    spi_frame_target #(.RATE_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .start(start),
        .test_en(test_en), .test_word(test_word), .sdo(sdo), .drdy(drdy)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the register-file writes described by R4 (24-bit or 32-bit frames).
    task automatic model_cmd(input logic [31:0] cmd, input int nbits, input int flen);
        if (nbits == flen && cmd[31:16] == 16'h0 && cmd[15:12] == 4'h8)
            mreg[cmd[11:8]] = cmd[7:0];
    endtask

    function automatic logic [7:0] sig(input bit fw, input bit te);
        logic [7:0] s = '0;
        for (int i = 0; i < 16; i++) s ^= mreg[i];
        return s ^ {fw, te, 6'b0};
    endfunction

    task automatic xfer(input logic [31:0] tx, input int nbits, input bit fw, output logic [31:0] rx);
        rx = '0;
        if (fw) begin cs_n = 1'b0; repeat (4) @(negedge clk); end
        for (int i = 0; i < nbits; i++) begin
            rx = {rx[30:0], sdo};
            sdi = tx[nbits-1-i];
            sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        if (fw) begin cs_n = 1'b1; repeat (4) @(negedge clk); end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rx;
        logic [23:0] prev, xw, c1, c2;
        int n, hits;
        for (int i = 0; i < 16; i++) mreg[i] = 8'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sdo after reset", {31'b0, sdo}, 32'h0);
        chk("R1 drdy after reset", {31'b0, drdy}, 32'h0);

        // R8: first pulse latency and period
        start = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!drdy && n < 5000);
        chk("R8 first pulse latency", n, DIV);
        n = 0;
        do begin @(negedge clk); n++; end while (!drdy && n < 5000);
        chk("R8 pulse period", n, DIV);

        // Vector table: edge-counted 24-bit frames; output is the word captured one frame earlier (R2, R9, R10)
        prev = '0;   // R1: first frame is all zero
        for (int v = 0; v < NVEC; v++) begin
            test_word = VEC[v][23:0];
            repeat (700) @(negedge clk);
            xfer({8'h0, VEC[v][47:24]}, 24, 1'b0, rx);
            model_cmd({8'h0, VEC[v][47:24]}, 24, 24);
            chk("R2 R9 R10 table frame", rx, {8'h0, prev});
            prev = VEC[v][23:0];
        end

        // R8: no pulses while stopped
        start = 1'b0;
        hits = 0;
        for (int i = 0; i < 2000; i++) begin @(negedge clk); if (drdy) hits++; end
        chk("R8 quiet while stopped", hits, 0);

        // R9: without a pulse the word repeats
        test_word = 24'h0BADC0;
        xfer(32'h0, 24, 1'b0, rx);
        chk("R9 last captured word", rx, {8'h0, prev});
        xfer(32'h0, 24, 1'b0, rx);
        chk("R9 stale word repeats", rx, {8'h0, prev});

        // R6: enable status in edge-counted mode; next frame is 32 bits
        start = 1'b1;
        xw = 24'h3C96E1;
        test_word = xw;
        repeat (700) @(negedge clk);
        xfer(32'h008101, 24, 1'b0, rx);
        model_cmd(32'h008101, 24, 24);
        chk("R6 frame before enable", rx, {8'h0, prev});
        xfer(32'h0, 32, 1'b0, rx);
        chk("R6 status plus result", rx, {sig(1'b0, 1'b1), xw});

        // R7: chip select high enters chip-select framing
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        xfer(32'h0, 32, 1'b1, rx);
        chk("R7 R6 framed by chip select", rx, {sig(1'b1, 1'b1), xw});
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        xfer(32'h0, 32, 1'b1, rx);
        chk("R7 sclk ignored while deselected", rx, {sig(1'b1, 1'b1), xw});

        // R11: short frame carries a clear command that must be dropped
        xfer(32'h008100, 24, 1'b1, rx);
        xfer(32'h0, 32, 1'b1, rx);
        chk("R11 short frame ignored", rx, {sig(1'b1, 1'b1), xw});

        // R4: full 32-bit write clears status enable; next frame 24 bits
        xfer(32'h00008100, 32, 1'b1, rx);
        model_cmd(32'h00008100, 32, 32);
        xfer(32'h0, 24, 1'b1, rx);
        chk("R4 write in 32-bit frame", rx, {8'h0, xw});

        // R10: counter source
        test_en = 1'b0;
        repeat (700) @(negedge clk);
        xfer(32'h0, 24, 1'b1, rx);
        repeat (700) @(negedge clk);
        xfer(32'h0, 24, 1'b1, rx);
        c1 = rx[23:0];
        repeat (700) @(negedge clk);
        xfer(32'h0, 24, 1'b1, rx);
        c2 = rx[23:0];
        chk("R10 counter nonzero", {31'b0, c1 != 0}, 32'h1);
        chk("R10 counter advances", {31'b0, c2 > c1}, 32'h1);

        // R1 R7: reset clears the mode latch and registers
        rst_n = 1'b0;
        cs_n = 1'b0;
        test_en = 1'b1;
        test_word = 24'hA1B2C3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mreg[i] = 8'h0;
        repeat (700) @(negedge clk);
        xfer(32'h0, 24, 1'b0, rx);
        chk("R1 first frame zero after reset", rx, 32'h0);
        xfer(32'h0, 24, 1'b0, rx);
        chk("R1 R7 edge framing after reset", rx, {8'h0, 24'hA1B2C3});

        summary();
        $finish;
    end
endmodule